// File: doc/BRIEF.md
# Fractional Cache Clock Ratio Generator

This block produces the clock for an external cache RAM interface. It runs from a reference clock at twice the core frequency. A 3-bit ratio code selects a divide ratio relative to the core clock. Whole ratios (1, 2, 3, 4) and half-integer ratios (1.5, 2.5, 3.5) are available, because one output period always lasts twice the ratio in reference cycles. Code zero parks the clock low and turns off the delay-line enable.

A ratio change never cuts a pulse short. The new code is adopted only when the current output period finishes, and each new period opens with a full high phase. Every adopted change also restarts a settle counter. This counter stands in for a delay-locked loop acquiring lock: a ready flag rises once a parameterized number of output periods have completed under the new code. A low-power stop request, qualified by a stop-enable input, parks the clock low at the end of the current period and lets it resume when the request is withdrawn.

Top module: `cache_clk_gen`

## Requirements
- R1: While reset is asserted, and right after it, `clk_out`, `dly_en` and `lock_ready` are all low, and the applied code is zero.
- R2: For an applied code, the output period in reference cycles is: 001 = 2, 010 = 3, 011 = 7, 100 = 4, 101 = 5, 110 = 6, 111 = 8. This is twice the ratios 1, 1.5, 3.5, 2, 2.5, 3 and 4.
- R3: Each period starts with its high phase. The high phase lasts floor(P/2) reference cycles and the low phase lasts the rest, so the duty cycle stays within one reference cycle of 50%.
- R4: With code 000 applied, `clk_out` stays low, `dly_en` is low and `lock_ready` is low.
- R5: `dly_en` is high exactly when the applied code is nonzero, and it only falls while `clk_out` is low.
- R6: A code presented on `ratio_code` is adopted only at the end of the current output period, or at once when the clock is parked. A high pulse already in progress keeps its old length, and so does the low phase that follows it.
- R7: Adopting a new code clears `lock_ready`. The flag rises at the edge that starts output period SETTLE_PERIODS+1 under the new code, that is, after SETTLE_PERIODS completed periods.
- R8: While `stop_req` and `stop_en` are both high, the clock parks low at the end of its current period. `dly_en` and `lock_ready` keep their values. When the request drops, a fresh period starts with a high phase.
- R9: When `stop_en` is low, `stop_req` has no effect on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Reference clock at twice the core frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Requested divide ratio code |
| stop_req | input | 1 | Low-power state active (request to park the clock) |
| stop_en | input | 1 | Allows `stop_req` to park the clock |
| clk_out | output | 1 | Divided clock for the cache RAM interface |
| dly_en | output | 1 | Delay-line enable, high for any nonzero applied code |
| lock_ready | output | 1 | Settle interval after the last code change has elapsed |

## Verification
The assertions check every cycle that the applied code only moves at a period boundary and that every rising edge of the output sits on such a boundary. They also check that a low `dly_en` implies a low clock, that `dly_en` never falls during a high phase, that a held stop request never lets the clock rise, and that the ready flag clears on every adoption and rises only on a period end. The exact period and high-phase length of each code, the count of periods before ready, the preserved length of a pulse interrupted by a code change, and resumption after a stop are only visible in the bench's scenarios. The bench measures these from the output waveform.

// File: rtl/cache_clk_pkg.sv
package cache_clk_pkg;
  localparam int CODE_W = 3;
  localparam int PER_W  = 4;

  typedef logic [CODE_W-1:0] ratio_t;
  typedef logic [PER_W-1:0]  per_t;

  // Output period in reference (2x) cycles for a ratio code; 0 means parked.
  function automatic per_t ratio_period(input ratio_t code);
    case (code)
      3'b001:  return per_t'(2);
      3'b010:  return per_t'(3);
      3'b011:  return per_t'(7);
      3'b100:  return per_t'(4);
      3'b101:  return per_t'(5);
      3'b110:  return per_t'(6);
      3'b111:  return per_t'(8);
      default: return per_t'(0);
    endcase
  endfunction

  // High-phase length: the shorter half of the period.
  function automatic per_t high_len(input per_t period);
    return period >> 1;
  endfunction
endpackage

// File: rtl/cache_clk_decode.sv
module cache_clk_decode
  import cache_clk_pkg::*;
(
  input  ratio_t code,
  output per_t   period
);
  assign period = ratio_period(code);
endmodule

// File: rtl/cache_clk_shaper.sv
module cache_clk_shaper
  import cache_clk_pkg::*;
(
  input  logic   clk2x,
  input  logic   rst_n,
  input  ratio_t code_in,
  input  logic   stop_hold,
  output logic   clk_q,
  output ratio_t act_code,
  output logic   boundary,
  output logic   apply_evt,
  output logic   period_end
);
  per_t   cnt;
  logic   running;
  per_t   act_per;
  per_t   act_high;
  per_t   nxt_per;
  per_t   cnt_inc;
  ratio_t nxt_code;

  cache_clk_decode act_dec_i (.code(act_code), .period(act_per));
  cache_clk_decode nxt_dec_i (.code(nxt_code), .period(nxt_per));

  assign act_high   = high_len(act_per);
  assign cnt_inc    = cnt + per_t'(1);
  assign boundary   = !running || (cnt == act_per - per_t'(1));
  assign apply_evt  = boundary && (code_in != act_code);
  assign nxt_code   = apply_evt ? code_in : act_code;
  assign period_end = running && boundary;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      running  <= 1'b0;
      cnt      <= '0;
      clk_q    <= 1'b0;
    end else if (boundary) begin
      act_code <= nxt_code;
      cnt      <= '0;
      if (nxt_per != '0 && !stop_hold) begin
        running <= 1'b1;
        clk_q   <= 1'b1;
      end else begin
        running <= 1'b0;
        clk_q   <= 1'b0;
      end
    end else begin
      cnt   <= cnt_inc;
      clk_q <= (cnt_inc < act_high);
    end
  end
endmodule

// File: rtl/cache_clk_settle.sv
module cache_clk_settle #(
  parameter int SETTLE_PERIODS = 16
) (
  input  logic clk2x,
  input  logic rst_n,
  input  logic apply_evt,
  input  logic period_end,
  output logic ready
);
  localparam int SW = $clog2(SETTLE_PERIODS + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SETTLE_PERIODS);

  logic [SW-1:0] done_cnt;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n)
      done_cnt <= '0;
    else if (apply_evt)
      done_cnt <= '0;
    else if (period_end && done_cnt != LIMIT)
      done_cnt <= done_cnt + SW'(1);
  end

  assign ready = (done_cnt == LIMIT);
endmodule

// File: rtl/cache_clk_gen.sv
module cache_clk_gen
  import cache_clk_pkg::*;
#(
  parameter int SETTLE_PERIODS = 16
) (
  input  logic       clk2x,
  input  logic       rst_n,
  input  logic [2:0] ratio_code,
  input  logic       stop_req,
  input  logic       stop_en,
  output logic       clk_out,
  output logic       dly_en,
  output logic       lock_ready
);
  ratio_t act_code;
  logic   boundary;
  logic   apply_evt;
  logic   period_end;
  logic   stop_hold;

  assign stop_hold = stop_req && stop_en;

  cache_clk_shaper shaper_i (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .code_in    (ratio_code),
    .stop_hold  (stop_hold),
    .clk_q      (clk_out),
    .act_code   (act_code),
    .boundary   (boundary),
    .apply_evt  (apply_evt),
    .period_end (period_end)
  );

  cache_clk_settle #(.SETTLE_PERIODS(SETTLE_PERIODS)) settle_i (
    .clk2x      (clk2x),
    .rst_n      (rst_n),
    .apply_evt  (apply_evt),
    .period_end (period_end),
    .ready      (lock_ready)
  );

  assign dly_en = (act_code != '0);
endmodule

// File: rtl/cache_clk_gen_chk.sv
module cache_clk_gen_chk (
  input logic       clk2x,
  input logic       rst_n,
  input logic       clk_out,
  input logic       dly_en,
  input logic       lock_ready,
  input logic       stop_req,
  input logic       stop_en,
  input logic       boundary,
  input logic       apply_evt,
  input logic       period_end,
  input logic [2:0] act_code
);
  assert_parked_low_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    !dly_en |-> !clk_out);

  assert_dly_fall_low_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(dly_en) |-> !clk_out);

  assert_code_at_boundary_R6: assert property (@(posedge clk2x) disable iff (!rst_n)
    !boundary |=> $stable(act_code));

  assert_rise_on_boundary_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(clk_out) |-> $past(boundary));

  assert_ready_clear_R7: assert property (@(posedge clk2x) disable iff (!rst_n)
    apply_evt |=> !lock_ready);

  assert_ready_rise_R7: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(lock_ready) |-> $past(period_end));

  assert_stop_holds_low_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
    (stop_req && stop_en && !clk_out) |=> !clk_out);
endmodule

bind cache_clk_gen cache_clk_gen_chk chk_i (
  .clk2x      (clk2x),
  .rst_n      (rst_n),
  .clk_out    (clk_out),
  .dly_en     (dly_en),
  .lock_ready (lock_ready),
  .stop_req   (stop_req),
  .stop_en    (stop_en),
  .boundary   (boundary),
  .apply_evt  (apply_evt),
  .period_end (period_end),
  .act_code   (act_code)
);

// File: tb/cache_clk_gen_tb_top.sv
module cache_clk_gen_tb_top;
  localparam int SETTLE = 16;
  localparam int NV = 7;
  // code, and output period expressed as ratio*2 reference cycles
  localparam int VCODE[NV] = '{1, 2, 3, 4, 5, 6, 7};
  localparam int VRX2[NV]  = '{2, 3, 7, 4, 5, 6, 8};

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic       stop_req = 1'b0;
  logic       stop_en = 1'b0;
  logic       clk_out, dly_en, lock_ready;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk2x = ~clk2x;

  cache_clk_gen #(.SETTLE_PERIODS(SETTLE)) dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .ratio_code(ratio_code),
    .stop_req(stop_req), .stop_en(stop_en),
    .clk_out(clk_out), .dly_en(dly_en), .lock_ready(lock_ready)
  );

  task automatic tick();
    @(negedge clk2x);
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (clk_out) highs++;
    end
  endtask

  task automatic wait_settle(output int rises);
    bit seen_low = 0;
    bit prev = clk_out;
    rises = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (!lock_ready) seen_low = 1;
      if (seen_low && clk_out && !prev) rises++;
      prev = clk_out;
      if (seen_low && lock_ready) break;
    end
  endtask

  task automatic wait_rise();
    bit prev = clk_out;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (clk_out && !prev) break;
      prev = clk_out;
    end
  endtask

  task automatic run_lengths(output int hi, output int lo);
    hi = 1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (!clk_out) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (clk_out) break;
      lo++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r, hi, lo, h;
    repeat (3) tick();
    check_eq("R1", "clk_out in reset", clk_out, 0);
    check_eq("R1", "dly_en in reset", dly_en, 0);
    check_eq("R1", "lock_ready in reset", lock_ready, 0);
    rst_n = 1'b1;

    count_high(20, h);
    check_eq("R4", "code0 highs", h, 0);
    check_eq("R4", "code0 dly_en", dly_en, 0);
    check_eq("R4", "code0 lock_ready", lock_ready, 0);

    for (int v = 0; v < NV; v++) begin
      ratio_code = 3'(VCODE[v]);
      wait_settle(r);
      check_eq("R7", $sformatf("rises to ready code%0d", VCODE[v]), r, SETTLE + 1);
      check_eq("R5", $sformatf("dly_en code%0d", VCODE[v]), dly_en, 1);
      wait_rise();
      run_lengths(hi, lo);
      check_eq("R3", $sformatf("high len code%0d", VCODE[v]), hi, VRX2[v] / 2);
      check_eq("R2", $sformatf("period code%0d", VCODE[v]), hi + lo, VRX2[v]);
    end

    // R6: switch from code 111 to 001 right after a rise; old pulse completes
    wait_rise();
    ratio_code = 3'd1;
    run_lengths(hi, lo);
    check_eq("R6", "interrupted high len", hi, 4);
    check_eq("R6", "interrupted low len", lo, 4);
    run_lengths(hi, lo);
    check_eq("R6", "new high len", hi, 1);
    check_eq("R6", "new period", hi + lo, 2);

    // R8: stop parks low, keeps enable and ready, then resumes
    ratio_code = 3'd4;
    wait_settle(r);
    stop_en = 1'b1;
    stop_req = 1'b1;
    repeat (10) tick();
    count_high(20, h);
    check_eq("R8", "highs while stopped", h, 0);
    check_eq("R8", "dly_en while stopped", dly_en, 1);
    check_eq("R8", "ready while stopped", lock_ready, 1);
    stop_req = 1'b0;
    wait_rise();
    check_eq("R8", "clk resumed", clk_out, 1);
    run_lengths(hi, lo);
    check_eq("R8", "period after resume", hi + lo, 4);

    // R9: request without enable is ignored
    stop_en = 1'b0;
    stop_req = 1'b1;
    count_high(24, h);
    check_eq("R9", "highs with stop_en low", h, 12);
    stop_req = 1'b0;

    // R4: back to code 0 while running
    ratio_code = 3'd0;
    repeat (10) tick();
    count_high(20, h);
    check_eq("R4", "highs after code0", h, 0);
    check_eq("R5", "dly_en after code0", dly_en, 0);
    check_eq("R4", "ready after code0", lock_ready, 0);

    // R1: reset in the middle of running
    ratio_code = 3'd6;
    wait_settle(r);
    rst_n = 1'b0;
    tick();
    check_eq("R1", "clk_out mid reset", clk_out, 0);
    check_eq("R1", "dly_en mid reset", dly_en, 0);
    check_eq("R1", "ready mid reset", lock_ready, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule